// File: doc/BRIEF.md
# Effective Address Unit

This block forms the memory address for load and store operations of a 32-bit load-store processor. The decoder hands it an addressing-mode code, an operand size and the operands that mode may need: a general register value, the index register value, a global base, a jump-table base, the program counter and a displacement field. One cycle after a request is accepted, the block presents the effective address. For the post-increment and pre-decrement modes it also presents the new value for the general register.

The jump-table mode takes two steps. First the block issues a one-cycle pointer read at the table base plus four times the 8-bit displacement, and holds a busy flag. When the read data comes back, the block presents that 32-bit pointer as the final address in the next cycle. Requests that arrive while the block is busy are dropped. The issuing stage must therefore stall on the busy flag.

All outputs are registered. Reset is synchronous and active high.

Top module: `eag_unit`

## Requirements
- R1: After reset, `ea_valid_o`, `wb_en_o`, `ptr_rd_o` and `busy_o` are all low.
- R2: A request with mode code 0 (register) accepted while idle gives `ea_valid_o` high in the next cycle, with `ea_o` equal to `reg_i` and `wb_en_o` low.
- R3: Mode code 1 (post-increment) gives `ea_o` = `reg_i` and `wb_en_o` high with `wb_val_o` = `reg_i` + step. The step is 1 for size code 0, 2 for size code 1, and 4 for size codes 2 and 3.
- R4: Mode code 2 (pre-decrement) gives both `ea_o` and `wb_val_o` equal to `reg_i` − step, with `wb_en_o` high.
- R5: Mode code 3 gives `reg_i` + zero-extended `disp_i[3:0]` × step. Mode code 4 gives `reg_i` + zero-extended `disp_i[11:0]` × step.
- R6: Mode code 5 gives `idx_i` + `reg_i`. Mode code 6 gives `idx_i` + `glb_base_i`.
- R7: Mode code 7 gives `glb_base_i` + zero-extended `disp_i[7:0]` × step.
- R8: Mode code 8 (PC literal) forms the address differently by size.
  - Size codes 2 and 3 give (`pc_i` with bits 1:0 cleared) + `disp_i[7:0]` × 4.
  - Size codes 0 and 1 give `pc_i` + `disp_i[7:0]` × 2.
- R9: Mode code 9 (table pointer) starts a two-step access.
  - In the cycle after acceptance, `ptr_rd_o` pulses for exactly one cycle with `ptr_addr_o` = `tbl_base_i` + `disp_i[7:0]` × 4, and `busy_o` rises.
  - `busy_o` stays high until `ptr_rvalid_i`.
  - In the cycle after `ptr_rvalid_i`, `ea_valid_o` is high with `ea_o` = `ptr_rdata_i`, `busy_o` is low and `wb_en_o` is low.
- R10: While `busy_o` is high, `req_valid_i` is ignored. While idle, `ptr_rvalid_i` is ignored. Neither produces an `ea_valid_o` pulse.
- R11: Mode codes 10 to 15 behave as mode code 0: `ea_o` = `reg_i`, no writeback.
- R12: `wb_en_o` is high only together with `ea_valid_o`, and only for mode codes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Address request strobe |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Operand size code: 0 byte, 1 word, 2 or 3 longword |
| reg_i | input | AW | General register value |
| idx_i | input | AW | Index register value |
| glb_base_i | input | AW | Global base register value |
| tbl_base_i | input | AW | Jump-table base register value |
| pc_i | input | AW | Program counter |
| disp_i | input | DISP_W | Displacement field |
| ptr_rdata_i | input | AW | Pointer read data |
| ptr_rvalid_i | input | 1 | Pointer read data valid |
| ea_valid_o | output | 1 | Effective address valid (one-cycle pulse) |
| ea_o | output | AW | Effective address |
| wb_en_o | output | 1 | General register writeback enable |
| wb_val_o | output | AW | General register writeback value |
| ptr_rd_o | output | 1 | Pointer read request (one-cycle pulse) |
| ptr_addr_o | output | AW | Pointer read address |
| busy_o | output | 1 | Table access in progress |

## Verification
A wrong offset scale or base selection shows up as a wrong `ea_o` in the cycle right after the request, so a directed stimulus per mode and size exposes it at once. A faulty writeback path shows up the same way: a wrong `wb_val_o`, or `wb_en_o` high for a mode that must not update the register.

Trouble in the table sequencer needs a wait to show. A state that drops out of the wait phase early leaves `busy_o` low and lets a dropped request through as an unexpected `ea_valid_o`. A state that never leaves it keeps `busy_o` high after `ptr_rvalid_i`, and that is visible one cycle later.

// File: rtl/eag_pkg.sv
package eag_pkg;

  // addressing-mode codes; the decoder drives these values
  localparam logic [3:0] AM_REG      = 4'd0;
  localparam logic [3:0] AM_POSTINC  = 4'd1;
  localparam logic [3:0] AM_PREDEC   = 4'd2;
  localparam logic [3:0] AM_DISP_S   = 4'd3;
  localparam logic [3:0] AM_DISP_L   = 4'd4;
  localparam logic [3:0] AM_IDX_REG  = 4'd5;
  localparam logic [3:0] AM_IDX_GLB  = 4'd6;
  localparam logic [3:0] AM_GLB_DISP = 4'd7;
  localparam logic [3:0] AM_PC_LIT   = 4'd8;
  localparam logic [3:0] AM_TBL_PTR  = 4'd9;

  // operand size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/eag_scaler.sv
// Zero-extends a narrow field and multiplies it by a power of two.
module eag_scaler #(
  parameter int IN_W = 8,
  parameter int AW   = 32
) (
  input  logic [IN_W-1:0] val_i,
  input  logic [1:0]      sh_i,
  output logic [AW-1:0]   out_o
);
  localparam int PAD_W = AW - IN_W;

  logic [AW-1:0] ext;
  assign ext   = {{PAD_W{1'b0}}, val_i};
  assign out_o = ext << sh_i;
endmodule

// File: rtl/eag_comb.sv
// Combinational address formation for every single-step mode,
// plus the pointer address of the table mode.
module eag_comb
  import eag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DISP_W = 12
) (
  input  logic [3:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [AW-1:0]     reg_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [AW-1:0]     glb_base_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [AW-1:0]     addr_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_val_o,
  output logic              is_tbl_o,
  output logic [AW-1:0]     tbl_addr_o
);
  localparam int SHORT_W = 4;
  localparam int MID_W   = 8;

  logic [1:0]    sz_sh;
  logic [1:0]    pc_sh;
  logic [AW-1:0] step;
  logic [AW-1:0] off_s, off_l, off_g, off_pc;
  logic [AW-1:0] pc_base;

  assign sz_sh   = (size_i == SZ_BYTE) ? 2'd0 : (size_i == SZ_WORD) ? 2'd1 : 2'd2;
  assign pc_sh   = (sz_sh == 2'd2) ? 2'd2 : 2'd1;
  assign step    = AW'(1) << sz_sh;
  assign pc_base = (pc_sh == 2'd2) ? {pc_i[AW-1:2], 2'b00} : pc_i;

  eag_scaler #(.IN_W(SHORT_W), .AW(AW)) u_sc_short (
    .val_i(disp_i[SHORT_W-1:0]), .sh_i(sz_sh), .out_o(off_s));
  eag_scaler #(.IN_W(DISP_W), .AW(AW)) u_sc_long (
    .val_i(disp_i), .sh_i(sz_sh), .out_o(off_l));
  eag_scaler #(.IN_W(MID_W), .AW(AW)) u_sc_glb (
    .val_i(disp_i[MID_W-1:0]), .sh_i(sz_sh), .out_o(off_g));
  eag_scaler #(.IN_W(MID_W), .AW(AW)) u_sc_pc (
    .val_i(disp_i[MID_W-1:0]), .sh_i(pc_sh), .out_o(off_pc));
  eag_scaler #(.IN_W(MID_W), .AW(AW)) u_sc_tbl (
    .val_i(disp_i[MID_W-1:0]), .sh_i(2'd2), .out_o(tbl_addr_o));

  // tbl_addr_o carries only the scaled offset out of the scaler; add base below
  logic [AW-1:0] tbl_off;
  assign tbl_off = tbl_addr_o;

  always_comb begin
    addr_o   = reg_i;
    wb_en_o  = 1'b0;
    wb_val_o = reg_i;
    is_tbl_o = 1'b0;
    case (mode_i)
      AM_POSTINC: begin
        wb_en_o  = 1'b1;
        wb_val_o = reg_i + step;
      end
      AM_PREDEC: begin
        addr_o   = reg_i - step;
        wb_en_o  = 1'b1;
        wb_val_o = reg_i - step;
      end
      AM_DISP_S:   addr_o = reg_i + off_s;
      AM_DISP_L:   addr_o = reg_i + off_l;
      AM_IDX_REG:  addr_o = idx_i + reg_i;
      AM_IDX_GLB:  addr_o = idx_i + glb_base_i;
      AM_GLB_DISP: addr_o = glb_base_i + off_g;
      AM_PC_LIT:   addr_o = pc_base + off_pc;
      AM_TBL_PTR: begin
        addr_o   = tbl_base_i + tbl_off;
        is_tbl_o = 1'b1;
      end
      default: addr_o = reg_i;
    endcase
  end
endmodule

// File: rtl/eag_seq.sv
// Output registers and the two-step table sequencer.
module eag_seq
  import eag_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          req_valid_i,
  input  logic          is_tbl_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wb_en_i,
  input  logic [AW-1:0] wb_val_i,
  input  logic [AW-1:0] ptr_rdata_i,
  input  logic          ptr_rvalid_i,
  output logic          ea_valid_o,
  output logic [AW-1:0] ea_o,
  output logic          wb_en_o,
  output logic [AW-1:0] wb_val_o,
  output logic          ptr_rd_o,
  output logic [AW-1:0] ptr_addr_o,
  output logic          busy_o
);
  seq_state_e st;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st         <= ST_IDLE;
      ea_valid_o <= 1'b0;
      ea_o       <= '0;
      wb_en_o    <= 1'b0;
      wb_val_o   <= '0;
      ptr_rd_o   <= 1'b0;
      ptr_addr_o <= '0;
    end else begin
      ea_valid_o <= 1'b0;
      wb_en_o    <= 1'b0;
      ptr_rd_o   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (is_tbl_i) begin
              ptr_rd_o   <= 1'b1;
              ptr_addr_o <= addr_i;
              st         <= ST_WAIT;
            end else begin
              ea_valid_o <= 1'b1;
              ea_o       <= addr_i;
              wb_en_o    <= wb_en_i;
              wb_val_o   <= wb_val_i;
            end
          end
        end
        ST_WAIT: begin
          if (ptr_rvalid_i) begin
            ea_valid_o <= 1'b1;
            ea_o       <= ptr_rdata_i;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st == ST_WAIT);
endmodule

// File: rtl/eag_unit.sv
module eag_unit #(
  parameter int AW     = 32,
  parameter int DISP_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_valid_i,
  input  logic [3:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic [AW-1:0]     reg_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [AW-1:0]     glb_base_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [AW-1:0]     ptr_rdata_i,
  input  logic              ptr_rvalid_i,
  output logic              ea_valid_o,
  output logic [AW-1:0]     ea_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_val_o,
  output logic              ptr_rd_o,
  output logic [AW-1:0]     ptr_addr_o,
  output logic              busy_o
);
  logic [AW-1:0] c_addr, c_wb_val, c_tbl_off;
  logic          c_wb_en, c_is_tbl;

  eag_comb #(.AW(AW), .DISP_W(DISP_W)) u_comb (
    .mode_i(mode_i), .size_i(size_i), .reg_i(reg_i), .idx_i(idx_i),
    .glb_base_i(glb_base_i), .tbl_base_i(tbl_base_i), .pc_i(pc_i),
    .disp_i(disp_i), .addr_o(c_addr), .wb_en_o(c_wb_en),
    .wb_val_o(c_wb_val), .is_tbl_o(c_is_tbl), .tbl_addr_o(c_tbl_off));

  eag_seq #(.AW(AW)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .req_valid_i(req_valid_i),
    .is_tbl_i(c_is_tbl), .addr_i(c_addr), .wb_en_i(c_wb_en),
    .wb_val_i(c_wb_val), .ptr_rdata_i(ptr_rdata_i),
    .ptr_rvalid_i(ptr_rvalid_i), .ea_valid_o(ea_valid_o), .ea_o(ea_o),
    .wb_en_o(wb_en_o), .wb_val_o(wb_val_o), .ptr_rd_o(ptr_rd_o),
    .ptr_addr_o(ptr_addr_o), .busy_o(busy_o));

  // the scaled table offset is already folded into c_addr inside u_comb
  logic unused_tbl_off;
  assign unused_tbl_off = ^c_tbl_off;
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
  parameter int AW     = 32,
  parameter int DISP_W = 12
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              req_valid_i,
  input logic [3:0]        mode_i,
  input logic [1:0]        size_i,
  input logic [AW-1:0]     reg_i,
  input logic [AW-1:0]     idx_i,
  input logic [AW-1:0]     glb_base_i,
  input logic [AW-1:0]     tbl_base_i,
  input logic [AW-1:0]     pc_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [AW-1:0]     ptr_rdata_i,
  input logic              ptr_rvalid_i,
  input logic              ea_valid_o,
  input logic [AW-1:0]     ea_o,
  input logic              wb_en_o,
  input logic [AW-1:0]     wb_val_o,
  input logic              ptr_rd_o,
  input logic [AW-1:0]     ptr_addr_o,
  input logic              busy_o
);
  localparam logic [3:0] TBL_CODE = 4'd9;

  logic [AW-1:0] tbl_expect;
  assign tbl_expect = tbl_base_i + {{(AW-10){1'b0}}, disp_i[7:0], 2'b00};

  a_r9_table_issue: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && !busy_o && mode_i == TBL_CODE)
      |=> (ptr_rd_o && busy_o && ptr_addr_o == $past(tbl_expect)));

  a_r9_ptr_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    ptr_rd_o |=> !ptr_rd_o);

  a_r9_return: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && ptr_rvalid_i)
      |=> (ea_valid_o && !busy_o && !wb_en_o && ea_o == $past(ptr_rdata_i)));

  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && !ptr_rvalid_i) |=> (busy_o && !ea_valid_o));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && !req_valid_i) |=> !ea_valid_o);

  a_r2_latency: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_valid_i && !busy_o && mode_i != TBL_CODE) |=> (ea_valid_o && !busy_o));

  a_r12_wb_mode: assert property (@(posedge clk_i) disable iff (rst_i)
    wb_en_o |-> (ea_valid_o && ($past(mode_i) == 4'd1 || $past(mode_i) == 4'd2)));

  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(busy_o && ea_valid_o));

  logic unused_chk;
  assign unused_chk = ^{size_i, reg_i, idx_i, glb_base_i, pc_i, disp_i[DISP_W-1:8],
                        wb_val_o};
endmodule

bind eag_unit eag_unit_chk #(.AW(AW), .DISP_W(DISP_W)) u_chk (.*);

// File: tb/eag_unit_bench.sv
module eag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 12;

  logic          clk_i = 1'b0;
  logic          rst_i = 1'b1;
  logic          req_valid_i = 1'b0;
  logic [3:0]    mode_i = '0;
  logic [1:0]    size_i = '0;
  logic [AW-1:0] reg_i = '0, idx_i = '0, glb_base_i = '0, tbl_base_i = '0, pc_i = '0;
  logic [DW-1:0] disp_i = '0;
  logic [AW-1:0] ptr_rdata_i = '0;
  logic          ptr_rvalid_i = 1'b0;
  logic          ea_valid_o, wb_en_o, ptr_rd_o, busy_o;
  logic [AW-1:0] ea_o, wb_val_o, ptr_addr_o;

  int checks = 0;
  int failures = 0;

  eag_unit #(.AW(AW), .DISP_W(DW)) u_eag_unit (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] step_of(logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R11";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic logic [AW-1:0] exp_ea(logic [3:0] m, logic [1:0] sz, logic [AW-1:0] rg,
      logic [AW-1:0] ix, logic [AW-1:0] gb, logic [AW-1:0] pc, logic [DW-1:0] d);
    logic [AW-1:0] s;
    s = step_of(sz);
    case (m)
      4'd2: return rg - s;
      4'd3: return rg + 32'(d[3:0]) * s;
      4'd4: return rg + 32'(d) * s;
      4'd5: return ix + rg;
      4'd6: return ix + gb;
      4'd7: return gb + 32'(d[7:0]) * s;
      4'd8: return (sz >= 2'd2) ? ((pc & ~32'd3) + 32'(d[7:0]) * 4) : (pc + 32'(d[7:0]) * 2);
      default: return rg;
    endcase
  endfunction

  task automatic set_ops(logic [3:0] m, logic [1:0] sz, logic [AW-1:0] rg, logic [AW-1:0] ix,
      logic [AW-1:0] gb, logic [AW-1:0] tb, logic [AW-1:0] pc, logic [DW-1:0] d);
    mode_i = m; size_i = sz; reg_i = rg; idx_i = ix;
    glb_base_i = gb; tbl_base_i = tb; pc_i = pc; disp_i = d;
  endtask

  // one single-step request, checked one cycle later
  task automatic t_single(logic [3:0] m, logic [1:0] sz, logic [AW-1:0] rg, logic [AW-1:0] ix,
      logic [AW-1:0] gb, logic [AW-1:0] pc, logic [DW-1:0] d);
    string tg;
    logic  wb;
    tg = tag_of(m);
    wb = (m == 4'd1 || m == 4'd2);
    @(negedge clk_i);
    set_ops(m, sz, rg, ix, gb, 32'h0, pc, d);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(tg, "ea_valid", 32'(ea_valid_o), 32'd1);
    chk(tg, "ea", ea_o, exp_ea(m, sz, rg, ix, gb, pc, d));
    chk(wb ? tg : "R12", "wb_en", 32'(wb_en_o), 32'(wb));
    if (m == 4'd1) chk("R3", "wb_val", wb_val_o, rg + step_of(sz));
    if (m == 4'd2) chk("R4", "wb_val", wb_val_o, rg - step_of(sz));
    @(negedge clk_i);
    chk("R12", "ea_valid pulse", 32'(ea_valid_o), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1", "ea_valid", 32'(ea_valid_o), 32'd0);
    chk("R1", "wb_en", 32'(wb_en_o), 32'd0);
    chk("R1", "ptr_rd", 32'(ptr_rd_o), 32'd0);
    chk("R1", "busy", 32'(busy_o), 32'd0);
  endtask

  task automatic t_all_modes;
    for (int sz = 0; sz < 4; sz++) begin
      for (int m = 0; m < 9; m++) begin
        t_single(4'(m), 2'(sz), 32'h1000_0040 + 32'(m), 32'h0000_0123, 32'h2000_0000,
                 32'h0000_8006, 12'hA5B);
      end
    end
  endtask

  task automatic t_boundaries;
    t_single(4'd1, 2'd2, 32'hFFFF_FFFE, 0, 0, 0, 0);        // R3 wrap
    t_single(4'd2, 2'd0, 32'h0000_0000, 0, 0, 0, 0);        // R4 wrap
    t_single(4'd4, 2'd2, 32'h0000_0000, 0, 0, 0, 12'hFFF);  // R5 max field
    t_single(4'd3, 2'd1, 32'h0000_0010, 0, 0, 0, 12'hFFF);  // R5 high bits ignored
    t_single(4'd8, 2'd2, 0, 0, 0, 32'h0000_0FFF, 12'h0FF);  // R8 align
    t_single(4'd8, 2'd1, 0, 0, 0, 32'h0000_0FFF, 12'h0FF);  // R8 word
    for (int m = 10; m < 16; m++) t_single(4'(m), 2'd1, 32'hCAFE_0000 + 32'(m), 1, 2, 3, 12'h7);
  endtask

  task automatic t_table(logic [AW-1:0] tb, logic [DW-1:0] d, logic [AW-1:0] ptr, int wait_cyc,
                         logic poke);
    @(negedge clk_i);
    set_ops(4'd9, 2'd0, 32'h5555_0000, 0, 0, tb, 0, d);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R9", "ptr_rd", 32'(ptr_rd_o), 32'd1);
    chk("R9", "ptr_addr", ptr_addr_o, tb + 32'(d[7:0]) * 4);
    chk("R9", "busy", 32'(busy_o), 32'd1);
    chk("R9", "ea_valid early", 32'(ea_valid_o), 32'd0);
    for (int i = 0; i < wait_cyc; i++) begin
      if (poke) begin
        set_ops(4'd0, 2'd0, 32'hDEAD_0000, 0, 0, 0, 0, 0);
        req_valid_i = 1'b1;
      end
      @(negedge clk_i);
      req_valid_i = 1'b0;
      chk(poke ? "R10" : "R9", "busy hold", 32'(busy_o), 32'd1);
      chk(poke ? "R10" : "R9", "no ea while busy", 32'(ea_valid_o), 32'd0);
      chk("R9", "ptr_rd single pulse", 32'(ptr_rd_o), 32'd0);
    end
    ptr_rdata_i = ptr;
    ptr_rvalid_i = 1'b1;
    @(negedge clk_i);
    ptr_rvalid_i = 1'b0;
    chk("R9", "final ea_valid", 32'(ea_valid_o), 32'd1);
    chk("R9", "final ea", ea_o, ptr);
    chk("R9", "busy clear", 32'(busy_o), 32'd0);
    chk("R9", "no writeback", 32'(wb_en_o), 32'd0);
    @(negedge clk_i);
    chk("R10", "no extra ea", 32'(ea_valid_o), 32'd0);
  endtask

  task automatic t_stray_rvalid;
    @(negedge clk_i);
    ptr_rdata_i = 32'h1234_5678;
    ptr_rvalid_i = 1'b1;
    @(negedge clk_i);
    ptr_rvalid_i = 1'b0;
    chk("R10", "stray rvalid ea_valid", 32'(ea_valid_o), 32'd0);
    chk("R10", "stray rvalid busy", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_i = 1'b0;
    t_reset();
    t_all_modes();
    t_boundaries();
    t_table(32'h0800_0000, 12'h0FF, 32'h0C00_1230, 0, 1'b0);
    t_table(32'hFFFF_FFF0, 12'h004, 32'h0000_0044, 3, 1'b0);
    t_table(32'h0000_1000, 12'hF10, 32'hABCD_EF00, 4, 1'b1);
    t_stray_rvalid();
    t_single(4'd0, 2'd2, 32'h0000_7777, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule